// File: doc/BRIEF.md
# Paired Center/Edge-Aligned PWM Generator

This block drives four pulse-width modulated lines from one shared time base. A counter runs either upward and wraps, which gives edge-aligned pulses, or up and then back down, which gives pulses that are symmetric about the period boundary. Each line compares the counter against its own active duty value. The lines form two pairs, lines 0/1 and lines 2/3. In paired operation the second line of each pair is the inverse of the first. In independent operation each of the four lines follows its own duty value.

The duty, period and mode inputs act as shadow values. The block copies them into its active registers only at permitted update points. Period and mode are taken only at the start of a period. Duty values are taken at the start of a period. In symmetric operation with the twice-per-period option, duty values are also taken at the turning point of the count. A one-cycle sync pulse marks the first cycle of every period. When the enable is low, the counter is held at zero and all outputs are low.

Top module: `pwm_pair_gen`

## Requirements
- R1: While `en_i` is low, and in the cycle after it falls, `pwm_o` is 4'b0000 and `sync_o` is 0. Reset also gives this state.
- R2: Edge-aligned (`center_i`=0) operation: a period of P cycles has counter values 0..P-1. Line i is high exactly while the counter is less than duty i, where duty i is `duty_i[i*W +: W]`.
- R3: Center-aligned (`center_i`=1) operation: a period of 2P cycles has counter values 0,1..P-1 and then P-1..1,0. Line i is high while the counter is less than duty i.
- R4: A duty of 0 keeps its line low for the whole period. A duty greater than or equal to P keeps its line high for the whole period.
- R5: With `paired_i`=1, `pwm_o[1]` is the inverse of `pwm_o[0]` and `pwm_o[3]` is the inverse of `pwm_o[2]`. Duty 1 and duty 3 then have no effect. With `paired_i`=0, all four lines follow their own duty values.
- R6: `sync_o` is high for exactly the first cycle of each period. That cycle is the upward cycle with counter 0.
- R7: Period, mode bits and (unless the double option is active) duty values are sampled only on the clock edge that begins a period. Changes made to them in mid-period do not affect the current period.
- R8: In center-aligned operation with `dbl_i`=1, duty values are also sampled on the edge that begins the downward half. That half uses the newly sampled duties, while period and mode stay unchanged.
- R9: After `en_i` rises, the first cycle after the sampling edge is a period start: `sync_o` is high, the counter is at 0, and the current inputs have been loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable |
| center_i | input | 1 | 1: up/down count, 0: wrapping up count |
| paired_i | input | 1 | 1: complementary pairs, 0: independent lines |
| dbl_i | input | 1 | 1: duty reload at start and turning point (center-aligned only) |
| period_i | input | CNT_W | Period P in counter steps |
| duty_i | input | 4*CNT_W | Four duty values, line i in bits i*CNT_W +: CNT_W |
| pwm_o | output | 4 | PWM lines |
| sync_o | output | 1 | One-cycle period-start pulse |

## Verification
Two functions can fall on the same clock edge: the shadow-to-active transfer, and the counter either reversing direction or wrapping to a new period. The bench provokes this by changing the duty inputs, and also the pairing bit, on the negative edge just before a turning point or a period boundary. It then predicts whether the very next cycle uses the old or the new values. In single-update operation the bench expects the old duties through the whole downward half. In double-update operation it expects the new duties from the first downward cycle. In both cases the mode change must wait for the next period start.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PWM_LANES = 4;

    typedef struct packed {
        logic center;
        logic paired;
        logic dbl;
    } pwm_mode_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  pwm_mode_t        mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dn_o,
    output logic             run_o,
    output logic [CNT_W-1:0] per_o,
    output pwm_mode_t        mode_o,
    output logic             sync_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dn;
        logic             run;
        logic [CNT_W-1:0] per;
        pwm_mode_t        mode;
    } tb_state_t;

    tb_state_t        st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             start_nx;
    logic             mid_nx;

    always_comb begin
        lim      = (st_q.per == '0) ? '0 : st_q.per - CNT_W'(1);
        st_d     = st_q;
        start_nx = 1'b0;
        mid_nx   = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
            st_d.dn  = 1'b0;
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            start_nx = 1'b1;
        end else if (!st_q.mode.center) begin
            if (st_q.cnt >= lim) start_nx = 1'b1;
            else                 st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (!st_q.dn) begin
            if (st_q.cnt >= lim) begin
                mid_nx  = 1'b1;
                st_d.dn = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            if (st_q.cnt == '0) start_nx = 1'b1;
            else                st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (start_nx) begin
            st_d.cnt  = '0;
            st_d.dn   = 1'b0;
            st_d.run  = 1'b1;
            st_d.per  = period_i;
            st_d.mode = mode_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upd_o  = start_nx | (mid_nx & st_q.mode.dbl);
    assign sync_o = st_q.run & (st_q.cnt == '0) & ~st_q.dn;
    assign cnt_o  = st_q.cnt;
    assign dn_o   = st_q.dn;
    assign run_o  = st_q.run;
    assign per_o  = st_q.per;
    assign mode_o = st_q.mode;
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
    parameter int CNT_W = 8,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_i,
    input  logic [LANES*CNT_W-1:0] duty_i,
    output logic [LANES*CNT_W-1:0] act_o
);
    logic [LANES*CNT_W-1:0] act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (upd_i) act_d = duty_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act_o = act_q;
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
    parameter int CNT_W = 8,
    parameter int LANES = 4
) (
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic [LANES*CNT_W-1:0] act_i,
    input  logic                   run_i,
    input  logic                   paired_i,
    output logic [LANES-1:0]       pwm_o
);
    localparam int PAIRS = LANES / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic lead_hi;
        logic trail_hi;
        assign lead_hi  = cnt_i < act_i[(2*p)*CNT_W +: CNT_W];
        assign trail_hi = cnt_i < act_i[(2*p+1)*CNT_W +: CNT_W];
        assign pwm_o[2*p]   = run_i & lead_hi;
        assign pwm_o[2*p+1] = run_i & (paired_i ? ~lead_hi : trail_hi);
    end
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       center_i,
    input  logic                       paired_i,
    input  logic                       dbl_i,
    input  logic [CNT_W-1:0]           period_i,
    input  logic [PWM_LANES*CNT_W-1:0] duty_i,
    output logic [PWM_LANES-1:0]       pwm_o,
    output logic                       sync_o
);
    pwm_mode_t                  mode_in;
    pwm_mode_t                  mode_w;
    logic [CNT_W-1:0]           cnt_w;
    logic [CNT_W-1:0]           per_w;
    logic                       dn_w;
    logic                       run_w;
    logic                       upd_w;
    logic [PWM_LANES*CNT_W-1:0] act_w;

    assign mode_in.center = center_i;
    assign mode_in.paired = paired_i;
    assign mode_in.dbl    = dbl_i;

    pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .mode_i   (mode_in),
        .cnt_o    (cnt_w),
        .dn_o     (dn_w),
        .run_o    (run_w),
        .per_o    (per_w),
        .mode_o   (mode_w),
        .sync_o   (sync_o),
        .upd_o    (upd_w)
    );

    pwm_duty_bank #(.CNT_W(CNT_W), .LANES(PWM_LANES)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (upd_w),
        .duty_i (duty_i),
        .act_o  (act_w)
    );

    pwm_cmp #(.CNT_W(CNT_W), .LANES(PWM_LANES)) u_cmp (
        .cnt_i    (cnt_w),
        .act_i    (act_w),
        .run_i    (run_w),
        .paired_i (mode_w.paired),
        .pwm_o    (pwm_o)
    );
endmodule

// File: rtl/pwm_pair_gen_chk.sv
module pwm_pair_gen_chk
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en_i,
    input logic [PWM_LANES-1:0]       pwm_o,
    input logic                       sync_o,
    input logic [CNT_W-1:0]           cnt,
    input logic                       dn,
    input logic                       run,
    input logic [CNT_W-1:0]           per,
    input pwm_mode_t                  mode,
    input logic [PWM_LANES*CNT_W-1:0] act
);
    logic [CNT_W-1:0] lim;
    logic [CNT_W:0]   cnt_nx;
    assign lim    = (per == '0) ? '0 : per - CNT_W'(1);
    assign cnt_nx = {1'b0, cnt} + (CNT_W+1)'(1);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pwm_o == '0 && !sync_o));

    // R3
    center_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en_i && mode.center && !dn && cnt_nx < {1'b0, per})
        |=> cnt == $past(cnt) + CNT_W'(1));

    // R4
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act[CNT_W-1:0] == '0) |-> !pwm_o[0]);

    // R4
    full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per != '0 && act[CNT_W-1:0] >= per) |-> pwm_o[0]);

    // R5
    pair_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode.paired) |-> (pwm_o[1] == !pwm_o[0] && pwm_o[3] == !pwm_o[2]));

    // R6
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && en_i && per > CNT_W'(1)) |=> !sync_o);

    // R7
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(mode.center && mode.dbl) && !$stable(act)) |-> sync_o);

    // R8
    double_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode.center && mode.dbl && !$stable(act))
        |-> (sync_o || (dn && cnt == lim)));
endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .pwm_o  (pwm_o),
    .sync_o (sync_o),
    .cnt    (cnt_w),
    .dn     (dn_w),
    .run    (run_w),
    .per    (per_w),
    .mode   (mode_w),
    .act    (act_w)
);

// File: tb/sim_pwm_pair_gen.sv
`timescale 1ns/1ps
module sim_pwm_pair_gen;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en_i = 1'b0;
    logic           center_i = 1'b0;
    logic           paired_i = 1'b0;
    logic           dbl_i = 1'b0;
    logic [W-1:0]   period_i = '0;
    logic [4*W-1:0] duty_i = '0;
    logic [3:0]     pwm_o;
    logic           sync_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] pwm;
        logic       sync;
        string      tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    pwm_pair_gen #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .center_i(center_i),
        .paired_i(paired_i), .dbl_i(dbl_i), .period_i(period_i),
        .duty_i(duty_i), .pwm_o(pwm_o), .sync_o(sync_o)
    );

    function automatic logic [3:0] exp_bits(int c, int d[4], bit pr);
        logic a0, a1, a2, a3;
        a0 = c < d[0];
        a1 = c < d[1];
        a2 = c < d[2];
        a3 = c < d[3];
        return pr ? {~a2, a2, ~a0, a0} : {a3, a2, a1, a0};
    endfunction

    task automatic set_in(bit en, bit ctr, bit pr, bit db, int p, int d[4]);
        en_i     = en;
        center_i = ctr;
        paired_i = pr;
        dbl_i    = db;
        period_i = W'(p);
        duty_i   = {W'(d[3]), W'(d[2]), W'(d[1]), W'(d[0])};
    endtask

    // expected cycles k0..k1-1 of one period
    task automatic push_span(int p, bit ctr, int k0, int k1, int d[4], bit pr, string tag);
        for (int k = k0; k < k1; k++) begin
            item_t it;
            int c;
            c = ctr ? ((k < p) ? k : 2*p - 1 - k) : k;
            it.pwm  = exp_bits(c, d, pr);
            it.sync = (k == 0);
            it.tag  = tag;
            q.push_back(it);
        end
    endtask

    task automatic push_idle(int n, string tag);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.pwm = 4'b0000; it.sync = 1'b0; it.tag = tag;
            q.push_back(it);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops one expected item per cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (pwm_o !== it.pwm || sync_o !== it.sync) begin
                    errors++;
                    $display("FAIL %s: pwm=%b sync=%b expected pwm=%b sync=%b",
                             it.tag, pwm_o, sync_o, it.pwm, it.sync);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        int da[4], db[4], dc[4];
        // reset state, R1
        repeat (4) @(negedge clk);
        checks++;
        if (pwm_o !== 4'b0000 || sync_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: pwm=%b sync=%b expected pwm=0000 sync=0", pwm_o, sync_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        push_idle(3, "R1 idle");
        repeat (3) @(negedge clk);

        // R9 R2 R4: edge aligned, independent, duty 0 and duty >= P
        da = '{3, 0, 8, 12};
        set_in(1, 0, 0, 0, 8, da);
        push_span(8, 0, 0, 8, da, 0, "R2 R4 R9 edge");
        repeat (8) @(negedge clk);
        da = '{5, 1, 7, 2};
        set_in(1, 0, 0, 0, 8, da);
        push_span(8, 0, 0, 8, da, 0, "R2 R6 edge reload");
        repeat (8) @(negedge clk);

        // R5: paired, duty 1 and 3 ignored
        da = '{2, 5, 4, 0};
        set_in(1, 0, 1, 0, 6, da);
        push_span(6, 0, 0, 6, da, 1, "R5 paired");
        repeat (6) @(negedge clk);

        // R3 R7: center single update, mid-period changes held off
        da = '{1, 2, 4, 6};
        set_in(1, 1, 0, 0, 5, da);
        push_span(5, 1, 0, 5, da, 0, "R3 center up");
        repeat (5) @(negedge clk);
        db = '{3, 0, 5, 2};
        set_in(1, 1, 1, 0, 5, db);
        push_span(5, 1, 5, 10, da, 0, "R7 single hold");
        repeat (5) @(negedge clk);
        push_span(5, 1, 0, 10, db, 1, "R3 R5 R7 next period");
        repeat (10) @(negedge clk);

        // R8: center double update
        da = '{2, 4, 1, 3};
        set_in(1, 1, 0, 1, 4, da);
        push_span(4, 1, 0, 4, da, 0, "R8 first half");
        repeat (4) @(negedge clk);
        db = '{4, 1, 3, 0};
        set_in(1, 1, 0, 1, 4, db);
        push_span(4, 1, 4, 8, db, 0, "R8 midpoint reload");
        repeat (4) @(negedge clk);
        dc = '{1, 1, 1, 1};
        set_in(1, 1, 0, 1, 4, dc);
        push_span(4, 1, 0, 4, dc, 0, "R8 start reload");
        repeat (4) @(negedge clk);

        // R1: disable mid-period
        en_i = 1'b0;
        push_idle(3, "R1 disable");
        repeat (3) @(negedge clk);

        // R9 R6: re-enable starts a fresh period
        da = '{1, 2, 3, 0};
        set_in(1, 0, 0, 0, 3, da);
        push_span(3, 0, 0, 3, da, 0, "R9 R6 restart");
        push_span(3, 0, 0, 3, da, 0, "R6 second period");
        repeat (6) @(negedge clk);
        en_i = 1'b0;
        push_idle(2, "R1 final");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule